// File: doc/BRIEF.md
# Memory Map Address Decoder

This block sits on an 8-bit processor bus with a 16-bit address. It turns the upper address bits into one active-low chip select per memory device. The chip selects are gated by an active-low memory request strobe. Three devices hang off the selects: a read-only store and two read/write stores. The block also answers reads itself, returning the byte of the selected device, or FFh where no device answers. Space with no device behind it reads as FFh and keeps nothing that is written to it.

A parameter picks one of two maps. The full map splits the space into four 16 KB windows using the top two address bits. Window 00 holds the read-only store, 01 is empty, 10 holds store A and 11 holds store B. The partial map looks only at the top address bit: 0 selects the read-only store and 1 selects store A. Store B is never used in that map. Every other upper bit is ignored, so one cell answers at many addresses. Each device model holds 2**CELL_AW bytes, 64 by default, and is indexed by the low address bits. In the full map, an in-window offset at or above that depth is a gap. A gap reads FFh and ignores writes, so every stored byte keeps exactly one address.

Chip selects and read data are combinational from the address and the strobes. Writes land on the rising clock edge. A reset synchronizer sits inside the block: it asserts asynchronously and releases two clocks after the reset input rises.

Top module: `memmap_decoder`

## Requirements
- R1: While mem_req_n is high, all three chip_sel_n bits are high and rd_data is FFh.
- R2: At no time is more than one chip_sel_n bit low.
- R3: With the full map and mem_req_n low, the address bits [15:14] decide the select. 00 drives chip_sel_n[0] low (read-only store), 10 drives chip_sel_n[1] low (store A), 11 drives chip_sel_n[2] low (store B), and 01 leaves all selects high.
- R4: With the full map, a read in window 01 returns FFh. A write there changes no stored byte.
- R5: The read-only store returns, at model index i (address bits [5:0]), the byte i XOR A5h. A write cycle aimed at it changes nothing that is read back afterwards.
- R6: A cycle with mem_req_n and wr_n low stores wr_data into the selected read/write store on the rising edge. A later read of that address returns the byte. Bytes that are not written keep their value.
- R7: After reset, every byte of both read/write stores reads 00h.
- R8: With the full map, an address whose bits [13:6] are not all zero still drives its window's chip select. Its read returns FFh and a write to it stores nothing.
- R9: With the partial map, bit 15 alone picks the device: 0 gives chip_sel_n[0] and 1 gives chip_sel_n[1]. chip_sel_n[2] stays high. Bits [14:6] are ignored, so a byte written at 8005h reads back at F045h and C005h.
- R10: While rd_n is high, rd_data is FFh, even when a device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes land on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| wr_data | input | 8 | Byte to be written |
| mem_req_n | input | 1 | Active-low memory request strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rd_data | output | 8 | Byte returned to the processor, FFh when nothing answers |
| chip_sel_n | output | 3 | Active-low selects: [0] read-only store, [1] store A, [2] store B |

## Verification
A wrong region decode shows in the same cycle: a chip select drops in the wrong window, or two selects drop together. A stuck or misrouted write enable is silent when it happens. It only shows on a later read, as a byte that changed in the read-only store, the empty window, a gap, or the other store. For that reason, every write in the bench is followed by readback from neighbouring regions and from the aliases. Aliasing errors show up only when a partial-map write is read back through a different upper-bit pattern. The bench therefore writes at one alias and reads at others.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;

  // device regions behind the decoder
  typedef enum logic [1:0] {
    REG_ROM   = 2'd0,
    REG_EMPTY = 2'd1,
    REG_RAM_A = 2'd2,
    REG_RAM_B = 2'd3
  } region_e;

  // chip select bit per device
  localparam int unsigned CS_ROM   = 0;
  localparam int unsigned CS_RAM_A = 1;
  localparam int unsigned CS_RAM_B = 2;
  localparam int unsigned NUM_CS   = 3;

endpackage

// File: rtl/mmdec_region_decode.sv
module mmdec_region_decode
  import mmdec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CELL_AW     = 6,
  parameter bit          PARTIAL_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req_n,
  output logic [NUM_CS-1:0] cs_n,
  output logic              in_window
);

  localparam int unsigned OFFS_TOP = ADDR_W - 3;

  region_e region;

  generate
    if (PARTIAL_MAP) begin : g_partial
      // only the top address line takes part in selection
      always_comb begin
        region    = addr[ADDR_W-1] ? REG_RAM_A : REG_ROM;
        in_window = 1'b1;
      end
    end else begin : g_full
      always_comb begin
        unique case (addr[ADDR_W-1 -: 2])
          2'b00:   region = REG_ROM;
          2'b01:   region = REG_EMPTY;
          2'b10:   region = REG_RAM_A;
          default: region = REG_RAM_B;
        endcase
        in_window = (addr[OFFS_TOP:CELL_AW] == '0);
      end
    end
  endgenerate

  always_comb begin
    cs_n = '1;
    if (!mem_req_n) begin
      unique case (region)
        REG_ROM:   cs_n[CS_ROM]   = 1'b0;
        REG_RAM_A: cs_n[CS_RAM_A] = 1'b0;
        REG_RAM_B: cs_n[CS_RAM_B] = 1'b0;
        default:   cs_n           = '1;
      endcase
    end
  end

  p_cs_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_n |-> (&cs_n));

  p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  generate
    if (PARTIAL_MAP) begin : g_chk_part
      p_no_store_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n[CS_RAM_B]);
    end else begin : g_chk_full
      p_empty_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1 -: 2] == 2'b01) |-> (&cs_n));
    end
  endgenerate

endmodule

// File: rtl/mmdec_rom_model.sv
module mmdec_rom_model #(
  parameter int unsigned CELL_AW = 6,
  parameter int unsigned DATA_W  = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
  input  logic [CELL_AW-1:0] idx,
  output logic [DATA_W-1:0]  rdata
);

  // contents are computed from the index; there is no write port
  always_comb rdata = DATA_W'(idx) ^ KEY;

endmodule

// File: rtl/mmdec_ram_model.sv
module mmdec_ram_model #(
  parameter int unsigned CELL_AW = 6,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CELL_AW-1:0] idx,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << CELL_AW;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0][DATA_W-1:0] mem_nxt;

  always_comb begin
    mem_nxt = mem_q;
    if (we) mem_nxt[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem_q <= '0;
    else if (we) mem_q <= mem_nxt;
  end

  always_comb rdata = mem_q[idx];

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_q));

  p_byte_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import mmdec_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CELL_AW     = 6,
  parameter bit          PARTIAL_MAP = 1'b0,
  parameter logic [DATA_W-1:0] ROM_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mem_req_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CS-1:0] chip_sel_n
);

  localparam logic [DATA_W-1:0] OPEN_BUS = '1;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic               in_window;
  logic [CELL_AW-1:0] cell_idx;
  logic               wr_ok;
  logic               we_a;
  logic               we_b;
  logic [DATA_W-1:0]  rom_q;
  logic [DATA_W-1:0]  ram_a_q;
  logic [DATA_W-1:0]  ram_b_q;

  // reset: asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign cell_idx = bus_addr[CELL_AW-1:0];

  mmdec_region_decode #(
    .ADDR_W      (ADDR_W),
    .CELL_AW     (CELL_AW),
    .PARTIAL_MAP (PARTIAL_MAP)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr      (bus_addr),
    .mem_req_n (mem_req_n),
    .cs_n      (chip_sel_n),
    .in_window (in_window)
  );

  mmdec_rom_model #(
    .CELL_AW (CELL_AW),
    .DATA_W  (DATA_W),
    .KEY     (ROM_KEY)
  ) u_rom (
    .idx   (cell_idx),
    .rdata (rom_q)
  );

  assign wr_ok = !wr_n && in_window;
  assign we_a  = wr_ok && !chip_sel_n[CS_RAM_A];

  mmdec_ram_model #(
    .CELL_AW (CELL_AW),
    .DATA_W  (DATA_W)
  ) u_ram_a (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (we_a),
    .idx   (cell_idx),
    .wdata (wr_data),
    .rdata (ram_a_q)
  );

  generate
    if (!PARTIAL_MAP) begin : g_store_b
      assign we_b = wr_ok && !chip_sel_n[CS_RAM_B];
      mmdec_ram_model #(
        .CELL_AW (CELL_AW),
        .DATA_W  (DATA_W)
      ) u_ram_b (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .we    (we_b),
        .idx   (cell_idx),
        .wdata (wr_data),
        .rdata (ram_b_q)
      );
    end else begin : g_no_store_b
      assign we_b    = 1'b0;
      assign ram_b_q = OPEN_BUS;
    end
  endgenerate

  // read return path
  always_comb begin
    rd_data = OPEN_BUS;
    if (!rd_n && in_window) begin
      if      (!chip_sel_n[CS_ROM])   rd_data = rom_q;
      else if (!chip_sel_n[CS_RAM_A]) rd_data = ram_a_q;
      else if (!chip_sel_n[CS_RAM_B]) rd_data = ram_b_q;
    end
  end

  p_idle_bus_high_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_n |-> (rd_data == OPEN_BUS));

  p_no_req_no_data_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_n |-> (rd_data == OPEN_BUS));

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(we_a && we_b));

endmodule

// File: tb/memmap_decoder_bench.sv
`timescale 1ns/1ps
module memmap_decoder_bench;

  typedef struct {
    logic [15:0] addr;
    logic [2:0]  cs_f;
    logic [2:0]  cs_p;
    logic [7:0]  rd_f;
    logic [7:0]  rd_p;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  wr_data;
  logic        mem_req_n, rd_n, wr_n;
  logic [7:0]  rd_f, rd_p;
  logic [2:0]  cs_f, cs_p;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  item_t sb_q[$];

  logic [7:0] sh_a [64];
  logic [7:0] sh_b [64];
  logic [7:0] sh_p [64];

  always #2.5 clk = ~clk;

  memmap_decoder #(.PARTIAL_MAP(1'b0)) u_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_data(wr_data),
    .mem_req_n(mem_req_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_data(rd_f), .chip_sel_n(cs_f));

  memmap_decoder #(.PARTIAL_MAP(1'b1)) u_memmap_decoder_part (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_data(wr_data),
    .mem_req_n(mem_req_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_data(rd_p), .chip_sel_n(cs_p));

  // reference model built from the requirements
  function automatic logic [2:0] ref_cs_full(logic [15:0] a, logic req_n);
    if (req_n) return 3'b111;
    case (a[15:14])
      2'b00:   return 3'b110;
      2'b01:   return 3'b111;
      2'b10:   return 3'b101;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] ref_cs_part(logic [15:0] a, logic req_n);
    if (req_n) return 3'b111;
    return a[15] ? 3'b101 : 3'b110;
  endfunction

  function automatic logic [7:0] ref_rd_full(logic [15:0] a, logic req_n, logic r_n);
    int i;
    i = int'(a[5:0]);
    if (req_n || r_n || a[13:6] != 8'd0) return 8'hFF;
    case (a[15:14])
      2'b00:   return {2'b00, a[5:0]} ^ 8'hA5;
      2'b01:   return 8'hFF;
      2'b10:   return sh_a[i];
      default: return sh_b[i];
    endcase
  endfunction

  function automatic logic [7:0] ref_rd_part(logic [15:0] a, logic req_n, logic r_n);
    if (req_n || r_n) return 8'hFF;
    return a[15] ? sh_p[int'(a[5:0])] : ({2'b00, a[5:0]} ^ 8'hA5);
  endfunction

  task automatic drive(input logic [15:0] a, input logic [7:0] d,
                       input logic rq, input logic r, input logic w, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; wr_data = d; mem_req_n = rq; rd_n = r; wr_n = w;
    it.addr = a;
    it.cs_f = ref_cs_full(a, rq);
    it.cs_p = ref_cs_part(a, rq);
    it.rd_f = ref_rd_full(a, rq, r);
    it.rd_p = ref_rd_part(a, rq, r);
    it.tag  = tag;
    sb_q.push_back(it);
    if (!rq && !w) begin
      if (a[13:6] == 8'd0 && a[15:14] == 2'b10) sh_a[int'(a[5:0])] = d;
      if (a[13:6] == 8'd0 && a[15:14] == 2'b11) sh_b[int'(a[5:0])] = d;
      if (a[15]) sh_p[int'(a[5:0])] = d;
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    drive(a, 8'h00, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    drive(a, d, 1'b0, 1'b1, 1'b0, tag);
  endtask

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp,
                     input string what, input item_t it);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", it.tag, what, it.addr, act, exp);
    end
  endtask

  // monitor: compare one queued item per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        cmp({5'd0, cs_f}, {5'd0, it.cs_f}, "cs full", it);
        cmp({5'd0, cs_p}, {5'd0, it.cs_p}, "cs partial", it);
        cmp(rd_f, it.rd_f, "data full", it);
        cmp(rd_p, it.rd_p, "data partial", it);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      sh_a[i] = 8'h00; sh_b[i] = 8'h00; sh_p[i] = 8'h00;
    end
    rst_n = 1'b0;
    bus_addr = 16'h0000; wr_data = 8'h00; mem_req_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    // reset state: idle bus
    drive(16'h8000, 8'h00, 1'b1, 1'b1, 1'b1, "R1 reset idle");
    drive(16'h0000, 8'h00, 1'b1, 1'b0, 1'b1, "R1 reset idle read");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(16'h8000, "R7 store A cleared");
    rd(16'hC03F, "R7 store B cleared");
    rd(16'h0000, "R5 R3 rom idx 0");
    rd(16'h0005, "R5 rom idx 5");
    rd(16'h003F, "R5 rom idx 63");
    rd(16'h4000, "R4 R3 empty window");
    rd(16'h7FFF, "R4 R8 empty top");

    wr(16'h8005, 8'h3C, "R6 write A");
    wr(16'hC005, 8'hC3, "R6 R9 write B alias");
    rd(16'h8005, "R6 R9 read A");
    rd(16'hC005, "R6 read B");
    rd(16'h8004, "R6 neighbour kept");

    wr(16'h0005, 8'h77, "R5 write rom");
    rd(16'h0005, "R5 rom unchanged");
    wr(16'h4005, 8'h55, "R4 write empty");
    rd(16'h4005, "R4 empty still FF");
    rd(16'h8005, "R4 A unchanged");
    rd(16'hC005, "R4 B unchanged");

    wr(16'h8045, 8'h99, "R8 R9 write gap");
    rd(16'h8005, "R8 gap not stored");
    rd(16'h8045, "R8 R9 gap read");
    rd(16'hF045, "R9 alias read");
    rd(16'h3FC5, "R9 R8 rom gap");

    drive(16'h8005, 8'h00, 1'b0, 1'b1, 1'b1, "R10 no read strobe");
    drive(16'h8005, 8'h00, 1'b1, 1'b0, 1'b1, "R1 no request");
    drive(16'h8006, 8'hEE, 1'b1, 1'b1, 1'b0, "R1 write without request");
    rd(16'h8006, "R1 write without request ignored");

    for (int i = 0; i < 8; i++) begin
      logic [15:0] off;
      off = 16'((i * 7 + 3) % 64);
      wr(16'h8000 | off, 8'((i * 37 + 1) & 255), "R6 sweep A");
      wr(16'hC000 | off, 8'((i * 53 + 9) & 255), "R6 sweep B");
      rd(16'h8000 | off, "R6 sweep read A");
      rd(16'hC000 | off, "R6 sweep read B");
      rd(16'hA000 | off, "R8 R9 sweep alias");
    end

    @(negedge clk);
    mem_req_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule